// File: doc/BRIEF.md
# USB Device Interrupt Status Register

This block gathers the interrupt causes of a USB device controller into one 16-bit status word and raises an active-low interrupt request while any cause is pending. Five causes are held as sticky flags: a change on the Vbus input, resume signalling on the bus lines, start-of-frame, a device-state transition and a control-transfer stage transition. A sixth bit shows the OR of a six-bit endpoint status vector, so it follows that vector and has no storage of its own here. The protocol engine reports events as one-cycle strobes. The device-state and control-stage strobes carry a code that names the factor, and each factor that can be masked is gated by its bit in an enable input.

Software acknowledges a flag by writing 0 to its bit. A 1 in the written word leaves that bit alone, so one write can acknowledge a chosen subset. The Vbus and resume detectors run on an always-on clock so that they still see bus activity while the controller clock is halted. Their results cross into the register clock through a two-stage synchronizer. A clock-running input tells the block whether software clears of those two flags may take effect.

Top module: `usb_irq_status`

## Requirements
- R1: Read word layout: bit 15 Vbus change, bit 14 resume, bit 13 start-of-frame, bit 12 device state, bit 11 control stage, bit 10 the OR of `ep_status[5:0]`; bits 9..0 always read 0.
- R2: A write with `wr_en` clears each of bits 15..11 whose written bit is 0 and leaves a flag unchanged where the written bit is 1; bit 10 is not affected by writes.
- R3: When a set event and a clearing write reach the same flag in one cycle, the flag ends up 1.
- R4: Every rising edge and every falling edge of `vbus` sets bit 15.
- R5: Line states are encoded `line_st` 2'b01 = J, 2'b10 = K, 2'b00 = SE0. A move from J to K or from J to SE0 sets bit 14, but only while `irq_en[8]` is 1; a move that does not start from J never sets it.
- R6: A clearing write to bit 15 or bit 14 takes effect only while `clk_run` is 1; while it is 0 those two bits keep their value.
- R7: A `sof_evt` strobe sets bit 13.
- R8: Control-stage codes on `ctrl_code`: 0 setup end, 1 control-write status, 2 control-read status, 3 transfer end, 4 sequence error. Code 0 always sets bit 11; codes 1..4 set it only if `irq_en[code-1]` is 1; codes 5..7 are ignored.
- R9: Device-state codes on `dev_code`: 0 bus reset, 1 suspend, 2 address set, 3 configuration set; code c sets bit 12 only if `irq_en[4+c]` is 1.
- R10: `irq_n` is 0 exactly when at least one of bits 15..10 of the read word is 1.
- R11: Reset clears bits 15..11. With `ep_status` at 0, `irq_n` is then 1.
- R12: Vbus and resume events are still latched while `clk_run` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset, held over several cycles of both clocks |
| aon_clk | input | 1 | Always-on clock for the Vbus and line-state detectors |
| clk_run | input | 1 | 1 when the controller clock counts as running |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Write word; a 0 bit acknowledges that flag |
| rd_data | output | 16 | Status read word |
| irq_n | output | 1 | Active-low interrupt request |
| sof_evt | input | 1 | Start-of-frame strobe |
| ctrl_evt | input | 1 | Control-stage event strobe |
| ctrl_code | input | 3 | Control-stage factor code |
| dev_evt | input | 1 | Device-state event strobe |
| dev_code | input | 2 | Device-state factor code |
| ep_status | input | 6 | Per-endpoint empty/size-error status |
| irq_en | input | 9 | Enable mask: [3:0] control factors 1..4, [7:4] device factors 0..3, [8] resume |
| vbus | input | 1 | Raw Vbus level |
| line_st | input | 2 | Raw bus line state |

## Verification
Each control-stage code is sent once with its enable set and once with it cleared. This separates the unmaskable setup factor from the maskable factors and from the unused codes. The device-state codes get the same treatment. Vbus is toggled in both directions, and the line state is stepped through J-to-K, J-to-SE0 and K-to-SE0, with the resume enable both on and off, so that legal wake transitions can be told apart from moves that start elsewhere. Acknowledge words that mix 0s and 1s, writes made while the clock is marked halted, and a write in the same cycle as an event show whether clears reach only the selected flags, are gated correctly, and lose no event.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int REG_W    = 16;
    localparam int FLAG_N   = 5;
    localparam int EP_NUM   = 6;
    localparam int POS_EP   = 10;
    localparam int POS_CTL  = 11;
    localparam int POS_DEV  = 12;
    localparam int POS_SOF  = 13;
    localparam int POS_RSM  = 14;
    localparam int POS_VBUS = 15;

    // index into the sticky-flag vector; flag[i] reads at bit POS_CTL+i
    typedef enum int {
        F_CTL  = 0,
        F_DEV  = 1,
        F_SOF  = 2,
        F_RSM  = 3,
        F_VBUS = 4
    } flag_idx_e;

    typedef enum logic [2:0] {
        CTL_SETUP_END = 3'd0,
        CTL_WR_STATUS = 3'd1,
        CTL_RD_STATUS = 3'd2,
        CTL_XFER_END  = 3'd3,
        CTL_SEQ_ERR   = 3'd4
    } ctl_code_e;

    typedef enum logic [1:0] {
        DEV_BUS_RESET = 2'd0,
        DEV_SUSPEND   = 2'd1,
        DEV_ADDR_SET  = 2'd2,
        DEV_CFG_SET   = 2'd3
    } dev_code_e;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10
    } line_state_e;

    typedef struct packed {
        logic       resm;
        logic [3:0] dev;
        logic [3:0] ctl;
    } irq_en_t;

    localparam int IEN_W = $bits(irq_en_t);

    // true for a line-state move that counts as resume signalling
    function automatic logic is_wake(input logic [1:0] prev, input logic [1:0] cur);
        return (prev == LS_J) && ((cur == LS_K) || (cur == LS_SE0));
    endfunction

endpackage

// File: rtl/usb_irq_aon_detect.sv
module usb_irq_aon_detect
    import usb_irq_pkg::*;
(
    input  logic       aon_clk,
    input  logic       rst,
    input  logic       vbus,
    input  logic [1:0] line_st,
    input  logic       resm_en,
    output logic       vbus_tgl,
    output logic       resm_tgl
);

    logic       vbus_q;
    logic [1:0] line_q;

    always_ff @(posedge aon_clk) begin
        if (rst) begin
            vbus_q   <= vbus;
            line_q   <= line_st;
            vbus_tgl <= 1'b0;
            resm_tgl <= 1'b0;
        end else begin
            vbus_q <= vbus;
            line_q <= line_st;
            if (vbus != vbus_q)
                vbus_tgl <= ~vbus_tgl;
            if (resm_en && is_wake(line_q, line_st))
                resm_tgl <= ~resm_tgl;
        end
    end

endmodule

// File: rtl/usb_irq_sync.sv
module usb_irq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++)
                pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/usb_irq_decode.sv
module usb_irq_decode
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sof_evt,
    input  logic              ctrl_evt,
    input  logic [2:0]        ctrl_code,
    input  logic              dev_evt,
    input  logic [1:0]        dev_code,
    input  irq_en_t           en,
    input  logic              vbus_tgl_s,
    input  logic              resm_tgl_s,
    output logic [FLAG_N-1:0] set_vec
);

    logic vbus_prev, resm_prev;
    logic ctl_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            vbus_prev <= 1'b0;
            resm_prev <= 1'b0;
        end else begin
            vbus_prev <= vbus_tgl_s;
            resm_prev <= resm_tgl_s;
        end
    end

    always_comb begin
        ctl_hit = 1'b0;
        case (ctrl_code)
            CTL_SETUP_END: ctl_hit = 1'b1;
            CTL_WR_STATUS: ctl_hit = en.ctl[0];
            CTL_RD_STATUS: ctl_hit = en.ctl[1];
            CTL_XFER_END:  ctl_hit = en.ctl[2];
            CTL_SEQ_ERR:   ctl_hit = en.ctl[3];
            default:       ctl_hit = 1'b0;
        endcase
    end

    always_comb begin
        set_vec         = '0;
        set_vec[F_CTL]  = ctrl_evt & ctl_hit;
        set_vec[F_DEV]  = dev_evt & en.dev[dev_code];
        set_vec[F_SOF]  = sof_evt;
        set_vec[F_RSM]  = resm_tgl_s ^ resm_prev;
        set_vec[F_VBUS] = vbus_tgl_s ^ vbus_prev;
    end

endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_N-1:0] set_vec,
    input  logic [FLAG_N-1:0] clr_vec,
    output logic [FLAG_N-1:0] flags
);

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;
            else if (clr_vec[i])
                flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         aon_clk,
    input  logic         clk_run,
    input  logic         wr_en,
    input  logic [15:0]  wr_data,
    output logic [15:0]  rd_data,
    output logic         irq_n,
    input  logic         sof_evt,
    input  logic         ctrl_evt,
    input  logic [2:0]   ctrl_code,
    input  logic         dev_evt,
    input  logic [1:0]   dev_code,
    input  logic [5:0]   ep_status,
    input  logic [8:0]   irq_en,
    input  logic         vbus,
    input  logic [1:0]   line_st
);

    irq_en_t           en;
    logic              vbus_tgl, resm_tgl;
    logic [1:0]        tgl_s;
    logic [FLAG_N-1:0] set_vec, clr_vec, flags;
    logic              ep_any;

    assign en = irq_en_t'(irq_en);

    usb_irq_aon_detect u_aon (
        .aon_clk  (aon_clk),
        .rst      (rst),
        .vbus     (vbus),
        .line_st  (line_st),
        .resm_en  (en.resm),
        .vbus_tgl (vbus_tgl),
        .resm_tgl (resm_tgl)
    );

    usb_irq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({vbus_tgl, resm_tgl}),
        .q   (tgl_s)
    );

    usb_irq_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .sof_evt    (sof_evt),
        .ctrl_evt   (ctrl_evt),
        .ctrl_code  (ctrl_code),
        .dev_evt    (dev_evt),
        .dev_code   (dev_code),
        .en         (en),
        .vbus_tgl_s (tgl_s[1]),
        .resm_tgl_s (tgl_s[0]),
        .set_vec    (set_vec)
    );

    always_comb begin
        clr_vec = '0;
        if (wr_en) begin
            clr_vec         = ~wr_data[POS_CTL +: FLAG_N];
            clr_vec[F_RSM]  = ~wr_data[POS_RSM] & clk_run;
            clr_vec[F_VBUS] = ~wr_data[POS_VBUS] & clk_run;
        end
    end

    usb_irq_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    assign ep_any = |ep_status;

    always_comb begin
        rd_data                    = '0;
        rd_data[POS_CTL +: FLAG_N] = flags;
        rd_data[POS_EP]            = ep_any;
    end

    assign irq_n = ~(ep_any | (|flags));

endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        clk_run,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        irq_n,
    input logic        sof_evt,
    input logic        ctrl_evt,
    input logic [2:0]  ctrl_code,
    input logic        dev_evt,
    input logic [1:0]  dev_code,
    input logic [5:0]  ep_status,
    input logic [8:0]  irq_en
);

    // R1: unused bits read zero, bit 10 follows the endpoint vector
    assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[9:0] == 10'd0);
    assert_ep_mirror_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[10] == (ep_status != 6'd0));

    // R2: a written 1 keeps a pending start-of-frame flag
    assert_write_one_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[13] && rd_data[13]) |=> rd_data[13]);
    assert_write_zero_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[13] && !sof_evt) |=> !rd_data[13]);

    // R3: event beats a simultaneous clear
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (sof_evt && wr_en && !wr_data[13]) |=> rd_data[13]);

    // R6: no clear of Vbus / resume while halted
    assert_halt_keeps_vbus_R6: assert property (@(posedge clk) disable iff (rst)
        (!clk_run && rd_data[15]) |=> rd_data[15]);
    assert_halt_keeps_resm_R6: assert property (@(posedge clk) disable iff (rst)
        (!clk_run && rd_data[14]) |=> rd_data[14]);

    // R7
    assert_sof_sets_R7: assert property (@(posedge clk) disable iff (rst)
        sof_evt |=> rd_data[13]);

    // R8: setup end cannot be masked
    assert_setup_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_evt && ctrl_code == 3'd0) |=> rd_data[11]);

    // R9: masked device factor leaves a clear flag clear
    assert_dev_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (dev_evt && !irq_en[4 + dev_code] && !rd_data[12]) |=> !rd_data[12]);

    // R10
    assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
        irq_n == (rd_data[15:10] == 6'd0));

    // R11
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (rd_data[15:11] == 5'd0));

endmodule

bind usb_irq_status usb_irq_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_run   (clk_run),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .irq_n     (irq_n),
    .sof_evt   (sof_evt),
    .ctrl_evt  (ctrl_evt),
    .ctrl_code (ctrl_code),
    .dev_evt   (dev_evt),
    .dev_code  (dev_code),
    .ep_status (ep_status),
    .irq_en    (irq_en)
);

// File: tb/usb_irq_status_test.sv
module usb_irq_status_test;

    localparam time CLK_PERIOD = 10ns;
    localparam time AON_PERIOD = 26ns;

    logic        clk = 1'b0;
    logic        aon_clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_run = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'hFFFF;
    logic [15:0] rd_data;
    logic        irq_n;
    logic        sof_evt = 1'b0;
    logic        ctrl_evt = 1'b0;
    logic [2:0]  ctrl_code = 3'd0;
    logic        dev_evt = 1'b0;
    logic [1:0]  dev_code = 2'd0;
    logic [5:0]  ep_status = 6'd0;
    logic [8:0]  irq_en = 9'd0;
    logic        vbus = 1'b0;
    logic [1:0]  line_st = 2'b01;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(AON_PERIOD/2) aon_clk = ~aon_clk;

    usb_irq_status uut (
        .clk(clk), .rst(rst), .aon_clk(aon_clk), .clk_run(clk_run),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n),
        .sof_evt(sof_evt), .ctrl_evt(ctrl_evt), .ctrl_code(ctrl_code),
        .dev_evt(dev_evt), .dev_code(dev_code), .ep_status(ep_status),
        .irq_en(irq_en), .vbus(vbus), .line_st(line_st)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (16) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'hFFFF;
    endtask

    task automatic clear_all();
        clk_run = 1'b1;
        write_word(16'h0000);
    endtask

    task automatic pulse_ctrl(input logic [2:0] c);
        @(negedge clk);
        ctrl_evt = 1'b1; ctrl_code = c;
        @(negedge clk);
        ctrl_evt = 1'b0;
    endtask

    task automatic pulse_dev(input logic [1:0] c);
        @(negedge clk);
        dev_evt = 1'b1; dev_code = c;
        @(negedge clk);
        dev_evt = 1'b0;
    endtask

    task automatic pulse_sof();
        @(negedge clk);
        sof_evt = 1'b1;
        @(negedge clk);
        sof_evt = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 reset word", rd_data, 16'h0000);
        check("R11 reset irq_n", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_layout();
        @(negedge clk); ep_status = 6'b100000;
        @(negedge clk);
        check("R1 endpoint bit 10", rd_data, 16'h0400);
        check("R10 irq from endpoint", {15'd0, irq_n}, 16'h0000);
        write_word(16'h0000);
        check("R2 write does not clear bit 10", rd_data, 16'h0400);
        @(negedge clk); ep_status = 6'd0;
        @(negedge clk);
        check("R1 endpoint vector cleared", rd_data, 16'h0000);
    endtask

    task automatic t_sof_partial();
        pulse_sof();
        check("R7 sof sets bit 13", rd_data, 16'h2000);
        check("R10 irq from sof", {15'd0, irq_n}, 16'h0000);
        pulse_ctrl(3'd0);
        write_word(16'hF7FF);
        check("R2 zero clears only bit 11", rd_data, 16'h2000);
        write_word(16'hDFFF);
        check("R2 zero clears bit 13", rd_data, 16'h0000);
        check("R10 irq released", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        sof_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h0000;
        @(negedge clk);
        sof_evt = 1'b0; wr_en = 1'b0; wr_data = 16'hFFFF;
        check("R3 set beats clear", rd_data, 16'h2000);
        clear_all();
    endtask

    task automatic t_ctrl();
        logic [15:0] exp;
        for (int c = 0; c < 8; c++) begin
            irq_en = 9'd0;
            pulse_ctrl(3'(c));
            exp = (c == 0) ? 16'h0800 : 16'h0000;
            check("R8 control code masked", rd_data, exp);
            clear_all();
            irq_en = 9'h00F;
            pulse_ctrl(3'(c));
            exp = (c <= 4) ? 16'h0800 : 16'h0000;
            check("R8 control code enabled", rd_data, exp);
            clear_all();
        end
        irq_en = 9'h00F & ~9'h004;
        pulse_ctrl(3'd3);
        check("R8 only own enable gates code 3", rd_data, 16'h0000);
        pulse_ctrl(3'd4);
        check("R8 code 4 via irq_en[3]", rd_data, 16'h0800);
        clear_all();
        irq_en = 9'd0;
    endtask

    task automatic t_dev();
        for (int c = 0; c < 4; c++) begin
            irq_en = 9'h0F0 & ~(9'h010 << c);
            pulse_dev(2'(c));
            check("R9 device code masked", rd_data, 16'h0000);
            irq_en = 9'h010 << c;
            pulse_dev(2'(c));
            check("R9 device code enabled", rd_data, 16'h1000);
            clear_all();
        end
        irq_en = 9'd0;
    endtask

    task automatic t_vbus();
        @(negedge clk); vbus = 1'b1;
        settle();
        check("R4 vbus rising", rd_data, 16'h8000);
        clear_all();
        check("R4 vbus cleared", rd_data, 16'h0000);
        @(negedge clk); vbus = 1'b0;
        settle();
        check("R4 vbus falling", rd_data, 16'h8000);
        clear_all();
    endtask

    task automatic t_resume();
        irq_en = 9'h100;
        line_st = 2'b01; settle(); clear_all();
        @(negedge clk); line_st = 2'b10;
        settle();
        check("R5 J to K", rd_data, 16'h4000);
        clear_all();
        @(negedge clk); line_st = 2'b00;
        settle();
        check("R5 K to SE0 ignored", rd_data, 16'h0000);
        @(negedge clk); line_st = 2'b01;
        settle();
        check("R5 SE0 to J ignored", rd_data, 16'h0000);
        @(negedge clk); line_st = 2'b00;
        settle();
        check("R5 J to SE0", rd_data, 16'h4000);
        clear_all();
        irq_en = 9'd0;
        @(negedge clk); line_st = 2'b01; settle();
        @(negedge clk); line_st = 2'b10; settle();
        check("R5 resume disabled", rd_data, 16'h0000);
        @(negedge clk); line_st = 2'b01; settle();
        clear_all();
    endtask

    task automatic t_halt();
        irq_en = 9'h100;
        @(negedge clk); clk_run = 1'b0; vbus = 1'b1;
        settle();
        check("R12 vbus latched while halted", rd_data, 16'h8000);
        @(negedge clk); line_st = 2'b10;
        settle();
        check("R12 resume latched while halted", rd_data, 16'hC000);
        pulse_sof();
        write_word(16'h0000);
        check("R6 halted clear ignored", rd_data, 16'hC000);
        @(negedge clk); clk_run = 1'b1;
        write_word(16'h7FFF);
        check("R6 running clear bit 15", rd_data, 16'h4000);
        write_word(16'h0000);
        check("R6 running clear bit 14", rd_data, 16'h0000);
        @(negedge clk); line_st = 2'b01; irq_en = 9'd0;
        settle();
        @(negedge clk); vbus = 1'b0;
        settle();
        clear_all();
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_sof_partial();
        t_set_wins();
        t_ctrl();
        t_dev();
        t_vbus();
        t_resume();
        t_halt();
        @(negedge clk); sof_evt = 1'b1;
        @(negedge clk); sof_evt = 1'b0; rst = 1'b1;
        repeat (12) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset clears pending flag", rd_data, 16'h0000);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule